// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Level Interrupts

This block gives software a word-addressed register window onto a bank of general-purpose pins. Each pin can be driven or left as an input. Every pin's value is read back through a two-stage synchronizer. Each pin can also raise a level-sensitive interrupt with a polarity chosen per pin. A separate mux-control word is stored and presented on an output port, so neighbouring pad logic can use it.

Interrupt status bits are sticky. A status bit is set while its pin sits at its active level and stays set after the level goes away. Software clears a bit by writing 1 to it. If the source is still active, the bit comes back on the next cycle. A per-pin enable mask gates the status bits onto one combined interrupt line.

The register bus is a plain single-cycle port with no handshake. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high. No back-pressure exists, because every access completes in the cycle in which it is presented.

Top module: `gpio_lvl_irq`

## Requirements
- R1: After reset, every register reads zero. `pin_oe`, `pin_out` and `mux_ctl` are zero and `irq_out` is low. All pins are therefore inputs, active-high and masked.
- R2: Word 1 is output data and word 2 is output enable. The low 12 bits of a write are stored in either word, and bits 12 to 31 read as zero. On the next cycle `pin_out` and `pin_oe` show the stored values, and a pin with its enable bit at 1 drives its output bit.
- R3: Word 0 is read-only and shows each pin's level after two clock edges of synchronization. Bits 12 to 31 read as zero.
- R4: Pin n takes its polarity from bit 4*(n mod 8). That bit is in word 5 for pins 0 to 7 and in word 6 for pins 8 to 11. A value of 0 selects active-high and 1 selects active-low. Only those bit positions are stored, and all other bits of words 5 and 6 read as zero.
- R5: Status is word 3. A status bit becomes 1 on the clock edge after its synchronized pin is seen at its active level. It stays 1 after the level goes away.
- R6: Writing to word 3 clears each status bit written as 1. Status bits written as 0 are left unchanged.
- R7: If a pin is at its active level in the cycle that its status bit is cleared, the bit stays 1. Setting takes priority over clearing.
- R8: Word 4 is the interrupt enable, with 1 meaning unmasked. `irq_out` is high exactly when some status bit and its enable bit are both 1.
- R9: Word 7 stores all 32 bits written to it. From the next cycle the stored value appears on `mux_ctl` and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 12 | Raw pin levels |
| pin_out | output | 12 | Output data per pin |
| pin_oe | output | 12 | Output driver enable per pin |
| mux_ctl | output | 32 | Stored mux-control word |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
On every cycle, the assertions check four things:
- status bits never drop except under a write-1 clear;
- an active synchronized level always leaves its status bit set on the next edge, whatever write arrives;
- an all-zero enable mask keeps `irq_out` low;
- writes to the output-enable and mux words appear on their ports one cycle later.

Some behaviour only the bench's scenarios can show:
- the two-edge input latency;
- the scattered polarity bit positions across the two type words;
- readback masking;
- a clear that sticks once the source has gone.

The bench compares these against a behavioural model at every clock.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned PINS_PER_TYP = 8;
  localparam int unsigned POL_STRIDE   = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_IN   = 3'd0,
    RG_OUT  = 3'd1,
    RG_OE   = 3'd2,
    RG_STA  = 3'd3,
    RG_IEN  = 3'd4,
    RG_TYP0 = 3'd5,
    RG_TYP1 = 3'd6,
    RG_MUX  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_lvl_irq_bank.sv
module gpio_lvl_irq_bank #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] sta,
  output logic         irq
);
  for (genvar n = 0; n < N; n++) begin : g_pin
    logic hit;
    logic flag_q;
    // polarity 1 selects active-low
    assign hit = lvl[n] ^ pol[n];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hit)    flag_q <= 1'b1;
      else if (clr[n]) flag_q <= 1'b0;
    end
    assign sta[n] = flag_q;
  end

  assign irq = |(sta & ien);
endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N_PINS      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [REG_W-1:0]  mux_ctl,
  output logic              irq_out
);
  localparam int unsigned PAD_W = REG_W - N_PINS;

  logic              wr_en;
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] out_q, oe_q, ien_q, pol_q, pol_nx, sta, sta_clr;
  logic [REG_W-1:0]  mux_q, typ0_rd, typ1_rd;

  assign wr_en = bus_sel & bus_wr;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  assign sta_clr = (wr_en && bus_addr == RG_STA) ? bus_wdata[N_PINS-1:0] : '0;

  gpio_lvl_irq_bank #(.N(N_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .pol(pol_q),
    .clr(sta_clr), .ien(ien_q), .sta(sta), .irq(irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
      ien_q <= '0;
      mux_q <= '0;
      pol_q <= '0;
    end else begin
      pol_q <= pol_nx;
      if (wr_en) begin
        case (bus_addr)
          RG_OUT:  out_q <= bus_wdata[N_PINS-1:0];
          RG_OE:   oe_q  <= bus_wdata[N_PINS-1:0];
          RG_IEN:  ien_q <= bus_wdata[N_PINS-1:0];
          RG_MUX:  mux_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // polarity bits are scattered at a fixed stride across two words
  always_comb begin
    pol_nx  = pol_q;
    typ0_rd = '0;
    typ1_rd = '0;
    for (int n = 0; n < int'(N_PINS); n++) begin
      if (n < int'(PINS_PER_TYP)) begin
        typ0_rd[POL_STRIDE*n] = pol_q[n];
        if (wr_en && bus_addr == RG_TYP0) pol_nx[n] = bus_wdata[POL_STRIDE*n];
      end else begin
        typ1_rd[POL_STRIDE*(n-PINS_PER_TYP)] = pol_q[n];
        if (wr_en && bus_addr == RG_TYP1)
          pol_nx[n] = bus_wdata[POL_STRIDE*(n-PINS_PER_TYP)];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        RG_IN:   bus_rdata = {{PAD_W{1'b0}}, pin_sync};
        RG_OUT:  bus_rdata = {{PAD_W{1'b0}}, out_q};
        RG_OE:   bus_rdata = {{PAD_W{1'b0}}, oe_q};
        RG_STA:  bus_rdata = {{PAD_W{1'b0}}, sta};
        RG_IEN:  bus_rdata = {{PAD_W{1'b0}}, ien_q};
        RG_TYP0: bus_rdata = typ0_rd;
        RG_TYP1: bus_rdata = typ1_rd;
        default: bus_rdata = mux_q;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign mux_ctl = mux_q;
endmodule

// File: rtl/gpio_lvl_irq_chk.sv
module gpio_lvl_irq_chk
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [IDX_W-1:0] bus_addr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [N-1:0]     pin_oe,
  input logic [REG_W-1:0] mux_ctl,
  input logic             irq_out,
  input logic [N-1:0]     pin_sync,
  input logic [N-1:0]     pol,
  input logic [N-1:0]     sta,
  input logic [N-1:0]     ien
);
  logic [N-1:0] clr_req;
  logic [N-1:0] act;

  assign clr_req = (bus_sel && bus_wr && bus_addr == RG_STA) ? bus_wdata[N-1:0] : '0;
  assign act     = pin_sync ^ pol;

  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && mux_ctl == '0 && !irq_out))
    else $error("R1 outputs not cleared after reset");

  assert_oe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == RG_OE) |=> (pin_oe == $past(bus_wdata[N-1:0])))
    else $error("R2 output enable did not follow write");

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sta) & ~$past(clr_req)) & ~sta) == '0))
    else $error("R5 status bit dropped without a clear");

  assert_level_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(act) & ~sta) == '0))
    else $error("R7 active level did not leave status set");

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq_out)
    else $error("R8 interrupt raised with all pins masked");

  assert_mux_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == RG_MUX) |=> (mux_ctl == $past(bus_wdata)))
    else $error("R9 mux word did not follow write");
endmodule

bind gpio_lvl_irq gpio_lvl_irq_chk #(.N(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
  .mux_ctl(mux_ctl), .irq_out(irq_out), .pin_sync(pin_sync),
  .pol(pol_q), .sta(sta), .ien(ien_q)
);

// File: tb/test_gpio_lvl_irq.sv
module test_gpio_lvl_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic [31:0] mux_ctl;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_lvl_irq i_gpio_lvl_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .mux_ctl(mux_ctl), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [11:0] m_s1, m_s2, m_out, m_oe, m_ien, m_sta;
  logic [31:0] m_typ0, m_typ1, m_mux;

  function automatic bit pol_of(int n);
    if (n < 8) return m_typ0[4*n];
    return m_typ1[4*(n-8)];
  endfunction

  function automatic logic [11:0] active_now();
    logic [11:0] a = '0;
    for (int n = 0; n < 12; n++) a[n] = pol_of(n) ? !m_s2[n] : m_s2[n];
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_out <= '0; m_oe <= '0; m_ien <= '0;
      m_sta <= '0; m_typ0 <= '0; m_typ1 <= '0; m_mux <= '0;
    end else begin
      logic [11:0] clr;
      clr = '0;
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd1: m_out  <= bus_wdata[11:0];
          3'd2: m_oe   <= bus_wdata[11:0];
          3'd3: clr     = bus_wdata[11:0];
          3'd4: m_ien  <= bus_wdata[11:0];
          3'd5: m_typ0 <= bus_wdata & 32'h1111_1111;
          3'd6: m_typ1 <= bus_wdata & 32'h0000_1111;
          3'd7: m_mux  <= bus_wdata;
          default: ;
        endcase
      end
      m_sta <= (m_sta & ~clr) | active_now();
    end
  end

  function automatic logic [31:0] rd_exp(logic [2:0] idx);
    case (idx)
      3'd0: return {20'd0, m_s2};
      3'd1: return {20'd0, m_out};
      3'd2: return {20'd0, m_oe};
      3'd3: return {20'd0, m_sta};
      3'd4: return {20'd0, m_ien};
      3'd5: return m_typ0;
      3'd6: return m_typ1;
      default: return m_mux;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison of the registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 pin_out", {20'd0, pin_out}, {20'd0, m_out});
      check("R2 pin_oe",  {20'd0, pin_oe},  {20'd0, m_oe});
      check("R9 mux_ctl", mux_ctl, m_mux);
      check("R8 irq_out", {31'd0, irq_out}, {31'd0, |(m_sta & m_ien)});
    end
  end

  task automatic wr(logic [2:0] idx, logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = idx; bus_wdata = data;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] idx, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx;
    #1;
    check(tag, bus_rdata, rd_exp(idx));
    bus_sel = 1'b0;
  endtask

  task automatic rd_lit(logic [2:0] idx, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx;
    #1;
    check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: all words zero after reset
    for (int i = 0; i < 8; i++) rd_lit(3'(i), 32'h0, "R1 reset read");
    check("R1 irq_out reset", {31'd0, irq_out}, 32'd0);

    // R2: output data and enable, upper bits masked
    wr(3'd1, 32'hFFFF_FFFF);
    rd_lit(3'd1, 32'h0000_0FFF, "R2 out readback");
    wr(3'd2, 32'h5A5A_50A5);
    rd_lit(3'd2, 32'h0000_00A5, "R2 oe readback");
    wr(3'd1, 32'h0000_0C3C);
    rd(3'd1, "R2 out pattern");

    // R3: two-edge synchronizer latency
    @(negedge clk); pin_in = 12'h9C3;
    rd(3'd0, "R3 input after one edge");
    rd_lit(3'd0, 32'h0000_09C3, "R3 input after two edges");
    @(negedge clk); pin_in = 12'h000;
    idle(4);
    rd_lit(3'd0, 32'h0, "R3 input cleared");

    // R6: clear everything with no active source
    wr(3'd3, 32'h0000_0FFF);
    rd_lit(3'd3, 32'h0, "R6 full clear");

    // R4: single polarity bit, then scattered positions
    wr(3'd5, 32'h0000_0010);
    rd_lit(3'd5, 32'h0000_0010, "R4 pin1 polarity readback");
    rd_lit(3'd3, 32'h0000_0002, "R4 pin1 active-low sets status");
    wr(3'd5, 32'hFFFF_FFFF);
    rd_lit(3'd5, 32'h1111_1111, "R4 type word 0 mask");
    wr(3'd6, 32'hFFFF_FFFF);
    rd_lit(3'd6, 32'h0000_1111, "R4 type word 1 mask");
    rd_lit(3'd3, 32'h0000_0FFF, "R4 all active-low set");

    // R5: sticky after source goes away
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0);
    idle(3);
    rd_lit(3'd3, 32'h0000_0FFF, "R5 status sticky");

    // R6: write 0 keeps, write 1 clears one bit
    wr(3'd3, 32'h0);
    rd_lit(3'd3, 32'h0000_0FFF, "R6 zero write no effect");
    wr(3'd3, 32'h0000_0008);
    rd_lit(3'd3, 32'h0000_0FF7, "R6 single bit clear");

    // R7: clear while source still active
    @(negedge clk); pin_in = 12'h020;
    idle(3);
    wr(3'd3, 32'h0000_0020);
    rd_lit(3'd3, 32'h0000_0FF7, "R7 set wins over clear");
    rd(3'd3, "R7 model compare");
    @(negedge clk); pin_in = 12'h000;
    idle(3);
    wr(3'd3, 32'h0000_0020);
    rd_lit(3'd3, 32'h0000_0FD7, "R7 clear after source gone");

    // R8: masking
    wr(3'd4, 32'h0000_0028);
    @(negedge clk); #1;
    check("R8 enabled bits clear", {31'd0, irq_out}, 32'd0);
    wr(3'd4, 32'h0000_0001);
    @(negedge clk); #1;
    check("R8 enabled bit set", {31'd0, irq_out}, 32'd1);
    wr(3'd3, 32'h0000_0001);
    @(negedge clk); #1;
    check("R8 irq drops after clear", {31'd0, irq_out}, 32'd0);
    rd(3'd4, "R8 enable readback");

    // R9: mux word
    wr(3'd7, 32'hA5C3_0F1E);
    rd_lit(3'd7, 32'hA5C3_0F1E, "R9 mux readback");
    check("R9 mux port", mux_ctl, 32'hA5C3_0F1E);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 1; i < 8; i++) rd_lit(3'(i), 32'h0, "R1 re-reset read");
    check("R1 mux after reset", mux_ctl, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule